// File: doc/BRIEF.md
# Serial-Bus Controller Interrupt Status and Enable Unit

This unit collects event strobes from a serial-bus controller's transfer engine into a 16-bit status word. Events include arbitration loss, a missing acknowledge, access ready, data ready in each direction, address matches, underflow, overrun and buffer drain. Each strobe sets a sticky bit. Software clears one or more of these bits by writing ones to them. A read-only bus-busy bit in the same word follows a live input. An enable word selects which sticky bits drive one level-sensitive interrupt line.

A third register holds a wakeup mask. Its sources are a mix of sticky status bits and three live event pulses that have no interrupt enable: general call, start condition and bus free. Transmit-ready and receive-ready share a single wakeup source. The unit drives a wakeup request whenever a selected source is active.

Software uses a simple register port. A write is taken on the clock edge when select and write are both high. Read data is combinational from the address.

Top module: `irq_status_unit`

## Requirements
- R1: Register addresses are 0 for status, 1 for enable and 2 for the wakeup mask. Address 3 reads zero. `reg_rdata` shows the addressed register combinationally.
- R2: A one on `evt_set` at a status position sets that status bit at the next clock edge, and the bit stays set. The status positions are 0 arb lost, 1 no-ack, 2 access ready, 3 rx ready, 4 tx ready, 8 address zero, 9 addressed as slave, 10 tx underflow, 11 rx overrun, 13 rx drain and 14 tx drain.
- R3: A write to address 0 clears each status bit whose data bit is one. Bits written with zero keep their value.
- R4: If an event sets a bit in the same cycle that a write clears it, the bit ends up set.
- R5: Status bit 12 equals the `bus_busy` input at all times. Writes to bit 12 have no effect.
- R6: Status positions 5, 6, 7 and 15 read zero, and `evt_set` at those positions is ignored. The enable register keeps only bits 0 to 4, 13 and 14; its other bits read zero.
- R7: `irq` is high exactly when a sticky status bit and its enable bit are both one. Bus-busy never raises `irq`.
- R8: The wakeup mask keeps only bits 0, 1, 2, 3, 5, 6, 8, 9, 13 and 14. `wake_req` is high when a masked source is active. The sources by mask bit are: 0, 1, 2, 9, 13 and 14 are the same status bits; 3 is status bit 3 or status bit 4; 5 is `evt_gcall`; 6 is `evt_start`; 8 is `evt_bfree`.
- R9: A clock edge with `rst_n` low clears status, enable and wakeup mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 1 | Register access select |
| reg_wr | input | 1 | Write strobe, qualified by reg_sel |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of addressed register |
| evt_set | input | 16 | Event strobes by status position |
| evt_gcall | input | 1 | General call seen (wakeup only) |
| evt_start | input | 1 | Start condition seen (wakeup only) |
| evt_bfree | input | 1 | Bus became free (wakeup only) |
| bus_busy | input | 1 | Live bus-busy state |
| irq | output | 1 | Level interrupt |
| wake_req | output | 1 | Wakeup request |

## Verification
A hardware event and a software write-one-clear can arrive in the same cycle and target the same status bit. The bench provokes this by holding an event strobe on a bit during the write cycle that clears it. The bit must read back set afterwards. A second case writes a clear of one bit while an event sets a different bit, and only the cleared bit may drop. The same-cycle rule is also covered by a property relating every strobed bit to the status word one cycle later.

// File: rtl/irq_status_unit.sv
module irq_status_unit #(
  parameter int DW = 16,
  parameter int AW = 2,
  parameter logic [DW-1:0] STICKY_BITS = 16'h6F1F,
  parameter logic [DW-1:0] ENA_BITS    = 16'h601F,
  parameter logic [DW-1:0] WAKE_BITS   = 16'h636F,
  parameter int BUSY_POS = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_sel,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic [DW-1:0] evt_set,
  input  logic          evt_gcall,
  input  logic          evt_start,
  input  logic          evt_bfree,
  input  logic          bus_busy,
  output logic          irq,
  output logic          wake_req
);
  localparam logic [AW-1:0] A_STAT = AW'(0);
  localparam logic [AW-1:0] A_ENA  = AW'(1);
  localparam logic [AW-1:0] A_WAKE = AW'(2);

  logic [DW-1:0] stat_q, en_q, wk_q;
  logic [DW-1:0] clr_vec, stat_view, wk_src;
  logic          wr_stat, wr_ena, wr_wake;

  assign wr_stat = reg_sel && reg_wr && (reg_addr == A_STAT);
  assign wr_ena  = reg_sel && reg_wr && (reg_addr == A_ENA);
  assign wr_wake = reg_sel && reg_wr && (reg_addr == A_WAKE);
  assign clr_vec = wr_stat ? reg_wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
      wk_q   <= '0;
    end else begin
      stat_q <= ((stat_q & ~clr_vec) | evt_set) & STICKY_BITS;
      if (wr_ena)  en_q <= reg_wdata & ENA_BITS;
      if (wr_wake) wk_q <= reg_wdata & WAKE_BITS;
    end
  end

  always_comb begin
    stat_view = stat_q;
    stat_view[BUSY_POS] = bus_busy;
  end

  always_comb begin
    unique case (reg_addr)
      A_STAT:  reg_rdata = stat_view;
      A_ENA:   reg_rdata = en_q;
      A_WAKE:  reg_rdata = wk_q;
      default: reg_rdata = '0;
    endcase
  end

  assign irq = |(stat_q & en_q);

  always_comb begin
    wk_src     = stat_q & 16'h6207;
    wk_src[3]  = stat_q[3] | stat_q[4];
    wk_src[5]  = evt_gcall;
    wk_src[6]  = evt_start;
    wk_src[8]  = evt_bfree;
  end

  assign wake_req = |(wk_src & wk_q);
endmodule

module irq_status_chk #(
  parameter int DW = 16,
  parameter int AW = 2,
  parameter logic [DW-1:0] STICKY_BITS = 16'h6F1F
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_sel,
  input logic          reg_wr,
  input logic [AW-1:0] reg_addr,
  input logic [DW-1:0] reg_wdata,
  input logic [DW-1:0] reg_rdata,
  input logic [DW-1:0] evt_set,
  input logic          bus_busy,
  input logic          irq,
  input logic [DW-1:0] stat_q,
  input logic [DW-1:0] en_q
);
  p_set_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_set & STICKY_BITS) != '0) |=>
      ((stat_q & $past(evt_set & STICKY_BITS)) == $past(evt_set & STICKY_BITS)));

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && reg_wr && reg_addr == '0) |=>
      ((stat_q & $past(reg_wdata & ~evt_set)) == '0));

  p_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_sel && reg_wr && reg_addr == '0) |=>
      ((stat_q & $past(stat_q)) == $past(stat_q)));

  p_busy_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == '0) |-> (reg_rdata[12] == bus_busy));

  p_unused_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == '0) |-> ((reg_rdata & 16'h80E0) == '0));

  p_no_enable_no_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq);

  p_enabled_event_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_set & en_q) != '0 && !(reg_sel && reg_wr && reg_addr == AW'(1))) |=> irq);
endmodule

bind irq_status_unit irq_status_chk #(.DW(DW), .AW(AW), .STICKY_BITS(STICKY_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .evt_set(evt_set), .bus_busy(bus_busy), .irq(irq),
  .stat_q(stat_q), .en_q(en_q)
);

// File: tb/sim_irq_status_unit.sv
module sim_irq_status_unit;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_sel = 0, reg_wr = 0;
  logic [1:0]  reg_addr = 0;
  logic [15:0] reg_wdata = 0, reg_rdata, evt_set = 0;
  logic        evt_gcall = 0, evt_start = 0, evt_bfree = 0, bus_busy = 0;
  logic        irq, wake_req;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  irq_status_unit u0 (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_set(evt_set), .evt_gcall(evt_gcall), .evt_start(evt_start),
    .evt_bfree(evt_bfree), .bus_busy(bus_busy), .irq(irq), .wake_req(wake_req)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    reg_sel = 1; reg_wr = 1; reg_addr = a; reg_wdata = d;
    tick();
    reg_sel = 0; reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic rd(input string req, input logic [1:0] a, input logic [15:0] exp);
    reg_addr = a; #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic pulse(input logic [15:0] e);
    evt_set = e; tick(); evt_set = 0;
  endtask

  task automatic t_reset();
    rd("R9", 2'd0, 16'h0000);
    rd("R9", 2'd1, 16'h0000);
    rd("R9", 2'd2, 16'h0000);
    rd("R1", 2'd3, 16'h0000);
    chk("R9", {15'd0, irq}, 16'h0);
    chk("R9", {15'd0, wake_req}, 16'h0);
  endtask

  task automatic t_sticky();
    pulse(16'h0001);
    rd("R2", 2'd0, 16'h0001);
    tick(); tick();
    rd("R2", 2'd0, 16'h0001);
    pulse(16'hFFFF);
    rd("R6", 2'd0, 16'h6F1F);
  endtask

  task automatic t_clear();
    wr(2'd0, 16'h0003);
    rd("R3", 2'd0, 16'h6F1C);
    wr(2'd0, 16'h0000);
    rd("R3", 2'd0, 16'h6F1C);
    wr(2'd0, 16'hFFFF);
    rd("R3", 2'd0, 16'h0000);
  endtask

  task automatic t_setwins();
    pulse(16'h0004);
    reg_sel = 1; reg_wr = 1; reg_addr = 2'd0; reg_wdata = 16'h0004; evt_set = 16'h0004;
    tick();
    reg_sel = 0; reg_wr = 0; evt_set = 0;
    rd("R4", 2'd0, 16'h0004);
    reg_sel = 1; reg_wr = 1; reg_addr = 2'd0; reg_wdata = 16'h0004; evt_set = 16'h0008;
    tick();
    reg_sel = 0; reg_wr = 0; evt_set = 0;
    rd("R4", 2'd0, 16'h0008);
    wr(2'd0, 16'hFFFF);
  endtask

  task automatic t_busy();
    wr(2'd1, 16'hFFFF);
    bus_busy = 1; #1;
    rd("R5", 2'd0, 16'h1000);
    chk("R7", {15'd0, irq}, 16'h0);
    wr(2'd0, 16'h1000);
    rd("R5", 2'd0, 16'h1000);
    bus_busy = 0; #1;
    rd("R5", 2'd0, 16'h0000);
  endtask

  task automatic t_enable();
    rd("R6", 2'd1, 16'h601F);
    pulse(16'h0100);
    chk("R7", {15'd0, irq}, 16'h0);
    pulse(16'h0008);
    chk("R7", {15'd0, irq}, 16'h1);
    wr(2'd0, 16'h0008);
    chk("R7", {15'd0, irq}, 16'h0);
    pulse(16'h4000);
    wr(2'd1, 16'h0000);
    chk("R7", {15'd0, irq}, 16'h0);
    wr(2'd1, 16'h4000);
    chk("R7", {15'd0, irq}, 16'h1);
    wr(2'd0, 16'hFFFF);
    wr(2'd1, 16'h0000);
  endtask

  task automatic t_wake();
    wr(2'd2, 16'hFFFF);
    rd("R8", 2'd2, 16'h636F);
    chk("R8", {15'd0, wake_req}, 16'h0);
    wr(2'd2, 16'h0008);
    pulse(16'h0010);
    chk("R8", {15'd0, wake_req}, 16'h1);
    wr(2'd0, 16'h0010);
    chk("R8", {15'd0, wake_req}, 16'h0);
    wr(2'd2, 16'h0040);
    evt_start = 1; #1;
    chk("R8", {15'd0, wake_req}, 16'h1);
    evt_start = 0; #1;
    chk("R8", {15'd0, wake_req}, 16'h0);
    wr(2'd2, 16'h0100);
    pulse(16'h0100);
    chk("R8", {15'd0, wake_req}, 16'h0);
    evt_bfree = 1; #1;
    chk("R8", {15'd0, wake_req}, 16'h1);
    evt_bfree = 0;
  endtask

  task automatic t_reset_again();
    wr(2'd1, 16'hFFFF);
    wr(2'd2, 16'hFFFF);
    pulse(16'h6F1F);
    rst_n = 0; tick(); rst_n = 1;
    rd("R9", 2'd0, 16'h0000);
    rd("R9", 2'd1, 16'h0000);
    rd("R9", 2'd2, 16'h0000);
    chk("R9", {15'd0, irq}, 16'h0);
  endtask

  initial begin
    #2;
    tick(); tick();
    rst_n = 1;
    t_reset();
    t_sticky();
    t_clear();
    t_setwins();
    t_busy();
    t_enable();
    t_wake();
    t_reset_again();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule